// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit (32-bit, register and immediate forms)

This block is the combinational execute datapath of a 32-bit integer core. It takes a first operand, a second operand, and a four-bit operation selector. It returns a 32-bit result in the same cycle. The operations are addition, subtraction, the three bitwise functions, left and right shifts (logical and arithmetic), and signed and unsigned less-than compares.

The second operand comes from one of two sources, picked by a select input. One source is a full 32-bit register value. The other is a 12-bit immediate, which is always widened by copying its bit 11 into every higher bit. The widening happens before any operation sees the value, so bitwise operations with an immediate act on the sign-extended word. Every shift takes its amount from bits 4:0 of the chosen second operand and ignores all higher bits. There are no flags, and no multiply or divide.

Top module: `rv_int_alu`

## Requirements
- R1: Selector 0 (add) returns A + B modulo 2^32.
- R2: Selector 1 (sub) returns A - B in two's complement modulo 2^32.
- R3: Selectors 2, 3 and 4 return the bitwise AND, OR and XOR of A and B. For example, 0x55551111 with 0xff00ff00 gives 0x55001100 for AND and 0xff55ff11 for OR.
- R4: Selector 5 (sll) shifts A left and fills with zeros. The amount is B[4:0], and B[31:5] has no effect. For example, 0x12345678 shifted by 8 gives 0x34567800.
- R5: Selector 6 (srl) shifts A right by B[4:0] and fills with zeros. For example, 0x87654321 shifted by 8 gives 0x00876543.
- R6: Selector 7 (sra) shifts A right by B[4:0] and fills with copies of A[31]. For example, 0x87654321 shifted by 8 gives 0xff876543.
- R7: Selector 8 (slt) returns 1 when A is less than B as signed 32-bit values, and 0 otherwise.
- R8: Selector 9 (sltu) returns 1 when A is less than B as unsigned values, and 0 otherwise.
- R9: When use_imm is 1, B is imm12 with bit 11 copied into bits 31:12. For example, A=0x55551111 gives 0x55551000 for AND with 0x800, 0x555511ee for XOR with 0x0ff, and 0xaaaae911 for XOR with 0x800.
- R10: Selector codes 10 to 15 return zero.
- R11: When use_imm is 0, B is the register operand and imm12 has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation selector (codes in R1 to R10) |
| src_a | input | 32 | First operand |
| src_b_reg | input | 32 | Register value for the second operand |
| imm12 | input | 12 | Immediate for the second operand |
| use_imm | input | 1 | 1 selects the sign-extended immediate as B |
| result | output | 32 | Operation result |

## Verification
Two functions can act in the same cycle: immediate sign extension and the shift-amount truncation. When a shift uses an immediate with bit 11 set, the extension fills bits 31:12 with ones, and the shifter must still use only bits 4:0. The bench sweeps all 4096 immediate values under sll, srl and sra, and under AND and XOR. It compares each result with a value computed arithmetically from the requirement text. It also sweeps all 64 values of B[5:0] under the three shifts with B[31:6] set to ones.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;

    localparam int XLEN   = 32;
    localparam int IMM_W  = 12;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SLL  = 4'd5,
        OP_SRL  = 4'd6,
        OP_SRA  = 4'd7,
        OP_SLT  = 4'd8,
        OP_SLTU = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic [XLEN-1:0] sum;
        logic [XLEN-1:0] diff;
        logic            lt_signed;
        logic            lt_unsigned;
    } arith_out_t;

    typedef struct packed {
        logic [XLEN-1:0] and_v;
        logic [XLEN-1:0] or_v;
        logic [XLEN-1:0] xor_v;
    } bitwise_out_t;

    typedef struct packed {
        logic to_left;
        logic sign_fill;
    } shift_mode_t;

    function automatic shift_mode_t mode_of(alu_op_e op);
        shift_mode_t m;
        m.to_left   = (op == OP_SLL);
        m.sign_fill = (op == OP_SRA);
        return m;
    endfunction

endpackage

// File: rtl/rv_opb_select.sv
module rv_opb_select
    import rv_alu_pkg::*;
#(
    parameter int WIDTH = XLEN,
    parameter int IW    = IMM_W
) (
    input  logic [WIDTH-1:0] reg_val,
    input  logic [IW-1:0]    imm,
    input  logic             pick_imm,
    output logic [WIDTH-1:0] opnd
);
    localparam int EXT_W = WIDTH - IW;

    logic [WIDTH-1:0] imm_wide;

    assign imm_wide = {{EXT_W{imm[IW-1]}}, imm};
    assign opnd     = pick_imm ? imm_wide : reg_val;

    // R9: the upper bits of the chosen operand all copy imm bit 11
    always_comb begin
        if (!$isunknown({pick_imm, imm, opnd}) && pick_imm) begin
            a_r9_imm_ext: assert ($countones(opnd[WIDTH-1:IW-1]) == (imm[IW-1] ? EXT_W + 1 : 0))
                else $error("R9 immediate extension mismatch");
        end
    end

endmodule

// File: rtl/rv_add_sub.sv
module rv_add_sub
    import rv_alu_pkg::*;
#(
    parameter int WIDTH = XLEN
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic [WIDTH-1:0] diff,
    output logic             lt_s,
    output logic             lt_u
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] sub_full;

    assign sum      = a + b;
    assign sub_full = {1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, 1'b1};
    assign diff     = sub_full[WIDTH-1:0];
    // carry out clear means a borrow happened
    assign lt_u     = ~sub_full[WIDTH];
    assign lt_s     = (a[MSB] ^ b[MSB]) ? a[MSB] : diff[MSB];

    always_comb begin
        if (!$isunknown({a, b})) begin
            a_r2_sub_inverse: assert (diff + b == a)
                else $error("R2 difference plus b differs from a");
            a_r8_ltu_not_equal: assert (!(lt_u && (a == b)))
                else $error("R8 unsigned less-than on equal operands");
            a_r7_lt_not_equal: assert (!(lt_s && (a == b)))
                else $error("R7 signed less-than on equal operands");
        end
    end

endmodule

// File: rtl/rv_shift_unit.sv
module rv_shift_unit
    import rv_alu_pkg::*;
#(
    parameter int WIDTH = XLEN,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data,
    input  logic [SHW-1:0]   amount,
    input  shift_mode_t      mode,
    output logic [WIDTH-1:0] shifted
);
    logic [WIDTH-1:0] data_rev;
    logic [WIDTH-1:0] last_rev;
    logic [WIDTH-1:0] stage [SHW+1];
    logic             fill;

    // left shift runs through the right shifter on bit-reversed data
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign data_rev[i] = data[WIDTH-1-i];
        assign last_rev[i] = stage[SHW][WIDTH-1-i];
    end

    assign fill     = mode.sign_fill & ~mode.to_left & data[WIDTH-1];
    assign stage[0] = mode.to_left ? data_rev : data;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 2 ** k;
        assign stage[k+1] = amount[k] ? {{STEP{fill}}, stage[k][WIDTH-1:STEP]} : stage[k];
    end

    assign shifted = mode.to_left ? last_rev : stage[SHW];

    always_comb begin
        if (!$isunknown({data, amount, mode}) && (amount != '0)) begin
            if (!mode.to_left && mode.sign_fill) begin
                a_r6_sra_sign: assert (shifted[WIDTH-1] == data[WIDTH-1])
                    else $error("R6 sign not replicated");
            end
            if (!mode.to_left && !mode.sign_fill) begin
                a_r5_srl_zero: assert (shifted[WIDTH-1] == 1'b0)
                    else $error("R5 logical right shift not zero filled");
            end
            if (mode.to_left) begin
                a_r4_sll_zero: assert (shifted[0] == 1'b0)
                    else $error("R4 left shift not zero filled");
            end
        end
    end

endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu
    import rv_alu_pkg::*;
(
    input  logic [OP_W-1:0]  op_sel,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b_reg,
    input  logic [IMM_W-1:0] imm12,
    input  logic             use_imm,
    output logic [XLEN-1:0]  result
);
    localparam int SHW = $clog2(XLEN);

    alu_op_e         op;
    logic [XLEN-1:0] opb;
    arith_out_t      ar;
    bitwise_out_t    bw;
    logic [XLEN-1:0] sh_out;

    assign op = alu_op_e'(op_sel);

    rv_opb_select #(.WIDTH(XLEN), .IW(IMM_W)) opb_i (
        .reg_val  (src_b_reg),
        .imm      (imm12),
        .pick_imm (use_imm),
        .opnd     (opb)
    );

    rv_add_sub #(.WIDTH(XLEN)) arith_i (
        .a    (src_a),
        .b    (opb),
        .sum  (ar.sum),
        .diff (ar.diff),
        .lt_s (ar.lt_signed),
        .lt_u (ar.lt_unsigned)
    );

    assign bw.and_v = src_a & opb;
    assign bw.or_v  = src_a | opb;
    assign bw.xor_v = src_a ^ opb;

    // only the low SHW bits of the second operand steer the shifter
    rv_shift_unit #(.WIDTH(XLEN), .SHW(SHW)) shift_i (
        .data    (src_a),
        .amount  (opb[SHW-1:0]),
        .mode    (mode_of(op)),
        .shifted (sh_out)
    );

    always_comb begin
        case (op)
            OP_ADD:  result = ar.sum;
            OP_SUB:  result = ar.diff;
            OP_AND:  result = bw.and_v;
            OP_OR:   result = bw.or_v;
            OP_XOR:  result = bw.xor_v;
            OP_SLL,
            OP_SRL,
            OP_SRA:  result = sh_out;
            OP_SLT:  result = {{(XLEN-1){1'b0}}, ar.lt_signed};
            OP_SLTU: result = {{(XLEN-1){1'b0}}, ar.lt_unsigned};
            default: result = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({op_sel, src_a, src_b_reg, imm12, use_imm})) begin
            if (op_sel > 4'd9) begin
                a_r10_undef_zero: assert (result == '0)
                    else $error("R10 undefined selector gave nonzero");
            end
            if (op_sel == 4'd8 || op_sel == 4'd9) begin
                a_r7_cmp_bool: assert (result[XLEN-1:1] == '0)
                    else $error("R7/R8 compare result not boolean");
            end
        end
    end

endmodule

// File: tb/rv_int_alu_tb.sv
module rv_int_alu_tb_top;

    logic        clk = 1'b0;
    logic [3:0]  op_sel;
    logic [31:0] src_a;
    logic [31:0] src_b_reg;
    logic [11:0] imm12;
    logic        use_imm;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    rv_int_alu dut_i (
        .op_sel    (op_sel),
        .src_a     (src_a),
        .src_b_reg (src_b_reg),
        .imm12     (imm12),
        .use_imm   (use_imm),
        .result    (result)
    );

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd5: return "R4";
            4'd6: return "R5";
            4'd7: return "R6";
            4'd8: return "R7";
            4'd9: return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [31:0] model(logic [3:0] op, logic [31:0] a, logic [31:0] b);
        int unsigned sh;
        sh = b % 32;
        case (op)
            4'd0: return a + b;
            4'd1: return a - b;
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return a ^ b;
            4'd5: return a << sh;
            4'd6: return a >> sh;
            4'd7: return 32'($signed(a) >>> sh);
            4'd8: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'd9: return (a < b) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    task automatic drive(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [11:0] im, logic sel);
        @(posedge clk);
        #1;
        op_sel    = op;
        src_a     = a;
        src_b_reg = b;
        imm12     = im;
        use_imm   = sel;
        @(negedge clk);
    endtask

    task automatic expect_val(string req, logic [31:0] exp);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h imm=%h sel=%0b actual=%h expected=%h",
                     req, op_sel, src_a, src_b_reg, imm12, use_imm, result, exp);
        end
    endtask

    task automatic run(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [11:0] im, logic sel);
        logic [31:0] bv;
        drive(op, a, b, im, sel);
        bv = sel ? {{20{im[11]}}, im} : b;
        expect_val(sel ? {tag_of(op), "/R9"} : tag_of(op), model(op, a, bv));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 60000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        // idle state: all-zero inputs give zero (R1)
        drive(4'd0, 32'h0, 32'h0, 12'h0, 1'b0);
        expect_val("R1", 32'h0);

        // directed values from the requirements
        drive(4'd0, 32'hffffffff, 32'h2, 12'h0, 1'b0);  expect_val("R1", 32'h1);
        drive(4'd1, 32'h0, 32'h1, 12'h0, 1'b0);         expect_val("R2", 32'hffffffff);
        drive(4'd2, 32'h55551111, 32'hff00ff00, 12'h0, 1'b0); expect_val("R3", 32'h55001100);
        drive(4'd3, 32'h55551111, 32'hff00ff00, 12'h0, 1'b0); expect_val("R3", 32'hff55ff11);
        drive(4'd5, 32'h12345678, 32'h8, 12'h0, 1'b0);  expect_val("R4", 32'h34567800);
        drive(4'd5, 32'h12345678, 32'hffffffe8, 12'h0, 1'b0); expect_val("R4", 32'h34567800);
        drive(4'd6, 32'h87654321, 32'h8, 12'h0, 1'b0);  expect_val("R5", 32'h00876543);
        drive(4'd7, 32'h87654321, 32'h8, 12'h0, 1'b0);  expect_val("R6", 32'hff876543);
        drive(4'd8, 32'hffffffff, 32'h1, 12'h0, 1'b0);  expect_val("R7", 32'h1);
        drive(4'd9, 32'hffffffff, 32'h1, 12'h0, 1'b0);  expect_val("R8", 32'h0);
        drive(4'd8, 32'h5, 32'h5, 12'h0, 1'b0);         expect_val("R7", 32'h0);
        drive(4'd2, 32'h55551111, 32'h0, 12'h800, 1'b1); expect_val("R9", 32'h55551000);
        drive(4'd4, 32'h55551111, 32'h0, 12'h0ff, 1'b1); expect_val("R9", 32'h555511ee);
        drive(4'd4, 32'h55551111, 32'h0, 12'h800, 1'b1); expect_val("R9", 32'haaaae911);
        drive(4'd15, 32'h12345678, 32'h9, 12'h0, 1'b0); expect_val("R10", 32'h0);

        // shift amounts: all 64 values of b[5:0] with upper bits set (R4 R5 R6)
        for (int op = 5; op <= 7; op++) begin
            for (int s = 0; s < 64; s++) begin
                run(4'(op), 32'h8badf00d, {26'h3ffffff, 6'(s)}, 12'h0, 1'b0);
            end
        end

        // random register-operand vectors on every selector (R1..R8, R10)
        for (int op = 0; op < 16; op++) begin
            for (int n = 0; n < 250; n++) begin
                run(4'(op), $urandom, (n % 5 == 0) ? 32'h0 : $urandom, 12'($urandom), 1'b0);
            end
        end

        // R11: immediate ignored when use_imm is 0
        for (int n = 0; n < 200; n++) begin
            run(4'd4, 32'hc3c3a5a5, 32'h0f0f1234, 12'($urandom), 1'b0);
        end

        // immediate sweep combined with shift truncation and logic ops (R9)
        for (int op = 2; op <= 7; op++) begin
            if (op == 3) continue;
            for (int im = 0; im < 4096; im++) begin
                run(4'(op), 32'h87654321, $urandom, 12'(im), 1'b1);
            end
        end

        // compare boundaries (R7 R8)
        run(4'd8, 32'h80000000, 32'h7fffffff, 12'h0, 1'b0);
        run(4'd9, 32'h80000000, 32'h7fffffff, 12'h0, 1'b0);
        run(4'd8, 32'h7fffffff, 32'h80000000, 12'h0, 1'b0);
        run(4'd9, 32'h7fffffff, 32'h80000000, 12'h0, 1'b0);
        run(4'd9, 32'h1, 32'h0, 12'hfff, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule